// File: doc/BRIEF.md
# Multi-class interrupt save-restore unit

This block keeps the saved processor context for a core that distinguishes four interrupt classes: noncritical (class 0), critical (class 1), debug (class 2) and machine check (class 3). Each class owns a save pair. Slot A of the pair holds a return address and slot B holds a machine-state word. When an exception is accepted, the block fills the pair of that class. It then redirects the core to a vector built from a base register and a programmable offset table. It also hands back an updated machine state in which the enables of the taken class and of every lower class are cleared.

Each class has its own return strobe. A return strobe reloads the machine state from slot B of that class and redirects to the address in slot A. Because every class has a separate pair, a higher-class handler can preempt a lower-class handler and leave that handler's saved context intact. Machine-check syndrome bits collect in a sticky register, and software clears them by writing ones. Redirect and state outputs are registered, so they appear one cycle after the request.

Top module: `irq_ctx_unit`

## Requirements
- R1: The register port maps save slot A of class c at address 2c and slot B at address 2c+1 (addresses 0..7), the syndrome at 8, the vector base at 9 and vector offset entry i at 16+i. Reads are combinational; unmapped addresses read 0. Writes take effect at the clock edge.
- R2: When an exception of class c is taken, slot A of class c receives pc_cur if exc_fault[c] is 1, and pc_next otherwise.
- R3: When an exception of class c is taken, slot B of class c receives the current machine-state word.
- R4: A request of class c is taken only if bit c of the machine-state word is 1. A request that is not taken changes no save slot and produces no redirect and no state load.
- R5: When several requests are taken at once, class 3 wins over class 2, class 2 over class 1, and class 1 over class 0. The pairs of the losing classes are unchanged.
- R6: One cycle after a take of class c, st_load is 1 and st_new equals the saved state with bits 0..c cleared. Bits above c and all bits from 4 upward are unchanged.
- R7: On a take, the redirect address is the upper W-OFF_W bits of the base concatenated with offset entry exc_vsel[4c+3:4c] of the winning class c.
- R8: A return strobe of class c alone gives, one cycle later, redir_pc equal to slot A of class c and st_new equal to slot B of class c. The strobe reads only that class's pair.
- R9: A take of a higher class while a lower handler runs leaves the lower class's pair unchanged, so the lower class can still return correctly afterwards.
- R10: Each machine-check take ORs syn_in into the syndrome register. A write to address 8 clears the bits written as 1. A disabled machine-check request does not change the syndrome.
- R11: When a return strobe and a request arrive in the same cycle, the exception wins. The enable check, the saved address and the saved state all use the post-return values (slot A and slot B of the returning class).
- R12: After reset all registers are 0, and redir_valid and st_load are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 4 | Exception request, one bit per class |
| exc_fault | input | 4 | 1: save the faulting PC; 0: save the next PC |
| exc_vsel | input | 4*VI | Vector table index for each class |
| pc_cur | input | W | Address of the current instruction |
| pc_next | input | W | Address of the next instruction |
| st_in | input | W | Live machine state; bit c enables class c |
| syn_in | input | YW | Machine-check syndrome bits |
| ret_req | input | 4 | Return strobe, one bit per class |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | W | Register read data |
| redir_valid | output | 1 | Redirect the fetch this cycle |
| redir_pc | output | W | Redirect target |
| st_load | output | 1 | Load st_new into the live state |
| st_new | output | W | Machine state to load |

## Verification
A corrupted save slot stays hidden until the return of its class. At that point it shows up as a wrong redir_pc or st_new one cycle after the strobe, which may be many cycles after the fault occurred. The bench therefore nests takes and unwinds them in order, and it also reads every slot back through the register port right after each take. A wrong priority or a wrong enable mask shows up on the very next cycle, as a wrong vector or wrong low bits of st_new. A syndrome that is lost or left unmasked is visible on the next read of address 8.

// File: rtl/irq_ctx_unit.sv
module irq_ctx_unit #(
  parameter int W     = 32,
  parameter int YW    = 8,
  parameter int OFF_W = 16,
  parameter int NVEC  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      exc_req,
  input  logic [3:0]      exc_fault,
  input  logic [4*$clog2(NVEC)-1:0] exc_vsel,
  input  logic [W-1:0]    pc_cur,
  input  logic [W-1:0]    pc_next,
  input  logic [W-1:0]    st_in,
  input  logic [YW-1:0]   syn_in,
  input  logic [3:0]      ret_req,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [4:0]      rd_addr,
  output logic [W-1:0]    rd_data,
  output logic            redir_valid,
  output logic [W-1:0]    redir_pc,
  output logic            st_load,
  output logic [W-1:0]    st_new
);
  localparam int VI = $clog2(NVEC);

  logic [W-1:0]     sr_a [4];
  logic [W-1:0]     sr_b [4];
  logic [YW-1:0]    synd;
  logic [W-1:0]     vbase;
  logic [OFF_W-1:0] voff [NVEC];

  logic [1:0]   rsel, tsel;
  logic [3:0]   grant, clr;
  logic [W-1:0] eff_st, cap_pc;
  logic [VI-1:0] vidx;
  logic [YW-1:0] mc_bits;

  wire ret_any = |ret_req;
  wire take    = |grant;

  always_comb begin
    rsel = 2'd0;
    for (int c = 0; c < 4; c++) if (ret_req[c]) rsel = 2'(c);
  end

  assign eff_st = ret_any ? sr_b[rsel] : st_in;
  assign grant  = exc_req & eff_st[3:0];

  always_comb begin
    tsel = 2'd0;
    for (int c = 0; c < 4; c++) if (grant[c]) tsel = 2'(c);
    for (int c = 0; c < 4; c++) clr[c] = (2'(c) <= tsel);
  end

  assign cap_pc  = ret_any ? sr_a[rsel] : (exc_fault[tsel] ? pc_cur : pc_next);
  assign vidx    = exc_vsel[int'(tsel)*VI +: VI];
  assign mc_bits = (take && tsel == 2'd3) ? syn_in : '0;

  always_comb begin
    rd_data = '0;
    if (rd_addr[4]) begin
      if (int'(rd_addr[3:0]) < NVEC) rd_data = W'(voff[rd_addr[VI-1:0]]);
    end else if (rd_addr[3] == 1'b0) begin
      rd_data = rd_addr[0] ? sr_b[rd_addr[2:1]] : sr_a[rd_addr[2:1]];
    end else if (rd_addr == 5'd8) begin
      rd_data = W'(synd);
    end else if (rd_addr == 5'd9) begin
      rd_data = vbase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        sr_a[c] <= '0;
        sr_b[c] <= '0;
      end
      for (int i = 0; i < NVEC; i++) voff[i] <= '0;
      synd        <= '0;
      vbase       <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      st_load     <= 1'b0;
      st_new      <= '0;
    end else begin
      redir_valid <= take | ret_any;
      st_load     <= take | ret_any;
      if (take) begin
        redir_pc <= {vbase[W-1:OFF_W], voff[vidx]};
        st_new   <= {eff_st[W-1:4], eff_st[3:0] & ~clr};
      end else if (ret_any) begin
        redir_pc <= sr_a[rsel];
        st_new   <= sr_b[rsel];
      end

      if (wr_en) begin
        for (int c = 0; c < 4; c++) begin
          if (wr_addr == 5'(2*c))   sr_a[c] <= wr_data;
          if (wr_addr == 5'(2*c+1)) sr_b[c] <= wr_data;
        end
        for (int i = 0; i < NVEC; i++)
          if (wr_addr == 5'(16+i)) voff[i] <= wr_data[OFF_W-1:0];
        if (wr_addr == 5'd9) vbase <= wr_data;
      end

      if (wr_en && wr_addr == 5'd8) synd <= (synd & ~wr_data[YW-1:0]) | mc_bits;
      else                          synd <= synd | mc_bits;

      if (take) begin
        sr_a[tsel] <= cap_pc;
        sr_b[tsel] <= eff_st;
      end
    end
  end
endmodule

module irq_ctx_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   exc_req,
  input logic [W-1:0] st_in,
  input logic [3:0]   ret_req,
  input logic         redir_valid,
  input logic         st_load,
  input logic [W-1:0] st_new
);
  p_take_redirects_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(exc_req & st_in[3:0])) && ret_req == 4'b0) |=> (redir_valid && st_load));

  p_blocked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_req & st_in[3:0]) == 4'b0 && ret_req == 4'b0) |=> (!redir_valid && !st_load));

  p_mc_masks_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req[3] && st_in[3] && ret_req == 4'b0) |=> (st_new[3:0] == 4'b0));

  p_higher_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req == 4'b0001 && st_in[0] && ret_req == 4'b0)
      |=> (st_new[W-1:1] == $past(st_in[W-1:1]) && !st_new[0]));

  p_load_with_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid == st_load);
endmodule

bind irq_ctx_unit irq_ctx_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .st_in(st_in), .ret_req(ret_req),
  .redir_valid(redir_valid), .st_load(st_load), .st_new(st_new)
);

// File: tb/irq_ctx_unit_bench.sv
module irq_ctx_unit_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] exc_req = '0, exc_fault = '0, ret_req = '0;
  logic [15:0] exc_vsel = '0;
  logic [W-1:0] pc_cur = '0, pc_next = '0, st_in = '0, wr_data = '0;
  logic [7:0] syn_in = '0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] rd_data, redir_pc, st_new;
  logic redir_valid, st_load;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_ctx_unit u_irq_ctx_unit (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [4:0] a, logic [W-1:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(logic [3:0] req, logic [3:0] flt, logic [3:0] ret, logic [W-1:0] st,
                      logic [W-1:0] pcc, logic [W-1:0] pcn, logic [7:0] syn);
    exc_req = req; exc_fault = flt; ret_req = ret; st_in = st;
    pc_cur = pcc; pc_next = pcn; syn_in = syn;
    @(negedge clk);
    exc_req = '0; ret_req = '0;
  endtask

  task automatic t_reset;
    chk("R12 redir_valid", W'(redir_valid), 0);
    chk("R12 st_load", W'(st_load), 0);
    rd("R12 slotA0", 5'd0, 0);
    rd("R12 syndrome", 5'd8, 0);
  endtask

  task automatic t_setup;
    wr(5'd9, 32'hABCD_1234);
    wr(5'd19, 32'h0000_0300);
    wr(5'd21, 32'h0000_0500);
    wr(5'd25, 32'h0000_0900);
    rd("R1 base", 5'd9, 32'hABCD_1234);
    rd("R1 table", 5'd21, 32'h0000_0500);
    wr(5'd3, 32'h1357_9BDF);
    rd("R1 slotB1 write", 5'd3, 32'h1357_9BDF);
    wr(5'd3, 32'h0);
  endtask

  task automatic t_take_nc;
    exc_vsel = 16'h0003;
    step(4'b0001, 4'b0001, 4'b0, 32'h5A00_000F, 32'h1000, 32'h1004, 8'h0);
    chk("R7 vector", redir_pc, 32'hABCD_0300);
    chk("R6 st_new", st_new, 32'h5A00_000E);
    chk("R6 st_load", W'(st_load), 1);
    rd("R2 fault pc", 5'd0, 32'h1000);
    rd("R3 state", 5'd1, 32'h5A00_000F);
    step(4'b0001, 4'b0000, 4'b0, 32'h5A00_000F, 32'h2000, 32'h2004, 8'h0);
    rd("R2 next pc", 5'd0, 32'h2004);
  endtask

  task automatic t_disabled;
    step(4'b0010, 4'b0010, 4'b0, 32'h0000_000D, 32'h3000, 32'h3004, 8'h0);
    chk("R4 no redirect", W'(redir_valid), 0);
    rd("R4 slotA1 kept", 5'd2, 0);
    rd("R4 slotB1 kept", 5'd3, 0);
  endtask

  task automatic t_priority;
    exc_vsel = 16'h9553;
    step(4'b1111, 4'b1111, 4'b0, 32'h0000_000F, 32'h4000, 32'h4004, 8'h0);
    chk("R5 vector mc", redir_pc, 32'hABCD_0900);
    chk("R5 mask", st_new, 32'h0);
    rd("R5 slotA3", 5'd6, 32'h4000);
    rd("R5 slotA2 kept", 5'd4, 0);
    rd("R5 slotA0 kept", 5'd0, 32'h2004);
    wr(5'd8, 32'hFF);
  endtask

  task automatic t_nest;
    exc_vsel = 16'h0053;
    step(4'b0001, 4'b0001, 4'b0, 32'h7000_000F, 32'hA000, 32'hA004, 8'h0);
    step(4'b0010, 4'b0010, 4'b0, 32'h7000_000E, 32'hB000, 32'hB004, 8'h0);
    chk("R6 crit keeps higher", st_new, 32'h7000_000C);
    chk("R7 crit vector", redir_pc, 32'hABCD_0500);
    rd("R9 nc slotA kept", 5'd0, 32'hA000);
    step(4'b0, 4'b0, 4'b0010, 32'h7000_000C, 0, 0, 8'h0);
    chk("R8 crit return pc", redir_pc, 32'hB000);
    chk("R8 crit return st", st_new, 32'h7000_000E);
    step(4'b0, 4'b0, 4'b0001, 32'h7000_000E, 0, 0, 8'h0);
    chk("R8 nc return pc", redir_pc, 32'hA000);
    chk("R8 nc return st", st_new, 32'h7000_000F);
    chk("R8 valid", W'(redir_valid), 1);
  endtask

  task automatic t_syndrome;
    step(4'b1000, 4'b0, 4'b0, 32'h8, 0, 0, 8'h05);
    step(4'b1000, 4'b0, 4'b0, 32'h8, 0, 0, 8'h30);
    rd("R10 accumulate", 5'd8, 32'h35);
    wr(5'd8, 32'h01);
    rd("R10 w1c", 5'd8, 32'h34);
    step(4'b1000, 4'b0, 4'b0, 32'h7, 0, 0, 8'h80);
    rd("R10 disabled no capture", 5'd8, 32'h34);
  endtask

  task automatic t_collision;
    wr(5'd0, 32'h0000_2000);
    wr(5'd1, 32'h0000_000F);
    exc_vsel = 16'h0050;
    step(4'b0010, 4'b0010, 4'b0001, 32'h0, 32'h9000, 32'h9004, 8'h0);
    chk("R11 exception wins", redir_pc, 32'hABCD_0500);
    chk("R11 state", st_new, 32'h0000_000C);
    rd("R11 saved pc", 5'd2, 32'h2000);
    rd("R11 saved st", 5'd3, 32'h0000_000F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_take_nc;
    t_disabled;
    t_priority;
    t_nest;
    t_syndrome;
    t_collision;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule